// File: doc/BRIEF.md
# Indexed-Register Programmable Interrupt Controller

This block collects a parameterized set of system interrupt lines, up to 1024, and combines them into one host interrupt request. Each line has its own trigger setting: rising edge, falling edge, active-high level or active-low level. The result goes into a per-line status bit, and a per-line enable bit gates that status. Every line also carries a one-byte channel number that sets its priority. A prioritized index register returns the number of the line that should be serviced next, so the interrupt handler needs only one read.

Software works through a plain 32-bit read/write register port. It can set or clear a single enable bit, or clear a single status bit, by writing the line number to an index register. It can also clear many bits at once through banked registers that hold 32 lines per word. Nested servicing, priority hold and a second fast host output are not part of this block. The two mode words at 0x04 and 0x0C therefore read as zero and ignore writes.

Top module: `idx_intc`

## Requirements
- R1: After reset, every enable, status, global and host enable bit is 0. Every channel byte is 7, every polarity bit is 1, every type bit is 0, `irq_o` is low, and the prioritized index (0x80) reads 0x8000_0000.
- R2: Writing v to 0x28 sets the enable of line v only, and writing v to 0x2C clears it. A value v of N_IRQ or more changes nothing. The enable bank at 0x380 + 4n reads back the enables of lines 32n..32n+31, with bit k being line 32n+k.
- R3: Writing v to 0x24 clears the latched status of line v only.
- R4: Writing a mask to 0x280 + 4n clears the status bits where the mask has a 1. Writing a mask to 0x380 + 4n does the same to the enable bits. A read of 0x280 + 4n returns the current status word.
- R5: The polarity bank (0xD00 + 4n) and the type bank (0xD80 + 4n) select the trigger per line. Type 1 with polarity 1 triggers on a rising edge, and type 1 with polarity 0 on a falling edge. Type 0 with polarity 1 is active-high level, and type 0 with polarity 0 is active-low level.
- R6: An edge-type status stays set until software clears it. An edge that arrives in the same cycle as a clear of that line wins, so the status stays set.
- R7: The channel map at 0x400 + 4n holds four lines per word. Byte j of the word (bits 8j+7:8j) is the channel of line 4n+j, and it reads back as written.
- R8: The prioritized index returns the winner in bits 9:0, or bit 31 set with all other bits 0 when nothing is pending. The winner is the pending, enabled line with the lowest channel number, and among lines on the same channel, the lowest line number.
- R9: `irq_o` is high exactly when bit 0 of 0x10 is 1, the host enable is set, and some line is both pending and enabled. Writing 0 to 0x34 sets the host enable and writing 0 to 0x38 clears it; other values written there are ignored.
- R10: Reads of unmapped offsets, of the index write registers and of 0x04/0x0C return 0. Writes to unmapped offsets leave all state unchanged.
- R11: An input change is reflected in status, and therefore in `irq_o`, at the first clock edge after the change. Read data appears on `rdata_o` at the clock edge that accepts the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IRQ | System interrupt lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Host interrupt request |

## Verification
Some properties are checked by assertions on every cycle. Whenever a winner is reported, it is a pending, enabled line. "None" is reported only when no enabled line is pending. The host request never rises without a reported winner and both enable gates set. An edge-latched status bit never drops without a clear, and an index-set write always leaves that line's enable bit set. Other behaviour can only be shown by the bench scenarios: the mapping of polarity and type to the four trigger modes, channel and tie-break ordering, set winning over a same-cycle clear, the byte layout of the channel map, and the read-as-zero and write-ignore behaviour of unmapped and write-only offsets.

// File: rtl/idx_intc_pkg.sv
package idx_intc_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 10;
  localparam int CH_W   = 8;

  typedef logic [CH_W-1:0] chan_t;

  localparam logic [ADDR_W-1:0] OFS_MODE      = 13'h004;
  localparam logic [ADDR_W-1:0] OFS_HMODE     = 13'h00C;
  localparam logic [ADDR_W-1:0] OFS_GLOB      = 13'h010;
  localparam logic [ADDR_W-1:0] OFS_STAT_ICLR = 13'h024;
  localparam logic [ADDR_W-1:0] OFS_EN_ISET   = 13'h028;
  localparam logic [ADDR_W-1:0] OFS_EN_ICLR   = 13'h02C;
  localparam logic [ADDR_W-1:0] OFS_HEN_ISET  = 13'h034;
  localparam logic [ADDR_W-1:0] OFS_HEN_ICLR  = 13'h038;
  localparam logic [ADDR_W-1:0] OFS_PRIO      = 13'h080;
  localparam logic [ADDR_W-1:0] BASE_STAT     = 13'h280;
  localparam logic [ADDR_W-1:0] BASE_EN       = 13'h380;
  localparam logic [ADDR_W-1:0] BASE_CHMAP    = 13'h400;
  localparam logic [ADDR_W-1:0] BASE_POL      = 13'hD00;
  localparam logic [ADDR_W-1:0] BASE_TYPE     = 13'hD80;

  function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, int w);
    return base + ADDR_W'(4 * w);
  endfunction
endpackage

// File: rtl/idx_intc_trigger.sv
module idx_intc_trigger #(
  parameter int N_IRQ = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] pol_i,
  input  logic [N_IRQ-1:0] typ_i,
  input  logic [N_IRQ-1:0] clr_i,
  output logic [N_IRQ-1:0] stat_o
);
  logic [N_IRQ-1:0] in_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_cell
    logic active, edge_hit;
    assign active   = ~(irq_i[i] ^ pol_i[i]);
    assign edge_hit = (irq_i[i] ^ in_q[i]) & active;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q[i]   <= 1'b0;
        stat_o[i] <= 1'b0;
      end else begin
        in_q[i] <= irq_i[i];
        // edge set wins over a same-cycle clear; level follows input
        if (typ_i[i]) stat_o[i] <= (stat_o[i] & ~clr_i[i]) | edge_hit;
        else          stat_o[i] <= active;
      end
    end
  end

  // R6
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_o & typ_i & ~clr_i) != '0) |=>
      (($past(stat_o & typ_i & ~clr_i) & typ_i & ~stat_o) == '0));
endmodule

// File: rtl/idx_intc_pick.sv
module idx_intc_pick
  import idx_intc_pkg::*;
#(
  parameter int N_IRQ = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IRQ-1:0]       pend_i,
  input  chan_t [N_IRQ-1:0]      chan_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       idx_o
);
  localparam int SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  chan_t best_ch;

  // strict compare keeps the lowest number on a channel tie
  always_comb begin
    found_o = 1'b0;
    best_ch = '1;
    idx_o   = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (pend_i[i] && (!found_o || chan_i[i] < best_ch)) begin
        found_o = 1'b1;
        best_ch = chan_i[i];
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R8
  win_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> pend_i[idx_o[SEL_W-1:0]]);

  // R8
  none_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_o |-> (pend_i == '0));
endmodule

// File: rtl/idx_intc.sv
module idx_intc
  import idx_intc_pkg::*;
#(
  parameter int N_IRQ = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int N_BANK = (N_IRQ + 31) / 32;
  localparam int N_MAPW = (N_IRQ + 3) / 4;
  localparam int SEL_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic [N_IRQ-1:0] en_q, pol_q, typ_q, stat;
  chan_t [N_IRQ-1:0] chmap_q;
  logic glob_q, hen_q;

  logic wr, rd, v_ok;
  logic [SEL_W-1:0] v_sel;
  logic [N_IRQ-1:0] clr_stat, en_set, en_clr;
  logic [DATA_W-1:0] rd_d;
  logic pick_found;
  logic [IDX_W-1:0] pick_idx;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign v_ok  = wdata_i < DATA_W'(N_IRQ);
  assign v_sel = wdata_i[SEL_W-1:0];

  always_comb begin
    clr_stat = '0;
    en_set   = '0;
    en_clr   = '0;
    if (wr) begin
      if (v_ok && addr_i == OFS_STAT_ICLR) clr_stat[v_sel] = 1'b1;
      if (v_ok && addr_i == OFS_EN_ISET)   en_set[v_sel]   = 1'b1;
      if (v_ok && addr_i == OFS_EN_ICLR)   en_clr[v_sel]   = 1'b1;
      for (int b = 0; b < N_BANK; b++) begin
        for (int k = 0; k < 32; k++) begin
          if (b * 32 + k < N_IRQ) begin
            if (addr_i == word_addr(BASE_STAT, b) && wdata_i[k]) clr_stat[b*32+k] = 1'b1;
            if (addr_i == word_addr(BASE_EN, b) && wdata_i[k])   en_clr[b*32+k]   = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '1;
      typ_q  <= '0;
      glob_q <= 1'b0;
      hen_q  <= 1'b0;
      for (int i = 0; i < N_IRQ; i++) chmap_q[i] <= chan_t'(7);
    end else begin
      en_q <= (en_q & ~en_clr) | en_set;
      if (wr) begin
        if (addr_i == OFS_GLOB) glob_q <= wdata_i[0];
        if (addr_i == OFS_HEN_ISET && wdata_i == '0) hen_q <= 1'b1;
        if (addr_i == OFS_HEN_ICLR && wdata_i == '0) hen_q <= 1'b0;
        for (int b = 0; b < N_BANK; b++) begin
          for (int k = 0; k < 32; k++) begin
            if (b * 32 + k < N_IRQ) begin
              if (addr_i == word_addr(BASE_POL, b))  pol_q[b*32+k] <= wdata_i[k];
              if (addr_i == word_addr(BASE_TYPE, b)) typ_q[b*32+k] <= wdata_i[k];
            end
          end
        end
        for (int w = 0; w < N_MAPW; w++) begin
          for (int j = 0; j < 4; j++) begin
            if (w * 4 + j < N_IRQ && addr_i == word_addr(BASE_CHMAP, w))
              chmap_q[w*4+j] <= wdata_i[8*j +: 8];
          end
        end
      end
    end
  end

  idx_intc_trigger #(.N_IRQ(N_IRQ)) i_trigger (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .pol_i  (pol_q),
    .typ_i  (typ_q),
    .clr_i  (clr_stat),
    .stat_o (stat)
  );

  idx_intc_pick #(.N_IRQ(N_IRQ)) i_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (stat & en_q),
    .chan_i  (chmap_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_comb begin
    rd_d = '0;
    if (addr_i == OFS_GLOB) rd_d = {{(DATA_W-1){1'b0}}, glob_q};
    if (addr_i == OFS_PRIO) rd_d = {~pick_found, {(DATA_W-IDX_W-1){1'b0}}, pick_idx};
    for (int b = 0; b < N_BANK; b++) begin
      for (int k = 0; k < 32; k++) begin
        if (b * 32 + k < N_IRQ) begin
          if (addr_i == word_addr(BASE_STAT, b)) rd_d[k] = stat[b*32+k];
          if (addr_i == word_addr(BASE_EN, b))   rd_d[k] = en_q[b*32+k];
          if (addr_i == word_addr(BASE_POL, b))  rd_d[k] = pol_q[b*32+k];
          if (addr_i == word_addr(BASE_TYPE, b)) rd_d[k] = typ_q[b*32+k];
        end
      end
    end
    for (int w = 0; w < N_MAPW; w++) begin
      for (int j = 0; j < 4; j++) begin
        if (w * 4 + j < N_IRQ && addr_i == word_addr(BASE_CHMAP, w))
          rd_d[8*j +: 8] = chmap_q[w*4+j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_d;
  end

  assign irq_o = glob_q & hen_q & (|(stat & en_q));

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pick_found && glob_q && hen_q));

  // R2
  en_iset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && v_ok && addr_i == OFS_EN_ISET) |=> en_q[$past(v_sel)]);
endmodule

// File: tb/test_idx_intc.sv
module test_idx_intc;
  localparam int N = 64;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [12:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq_o;
  logic          rd_seen = 1'b0;
  exp_t          q[$];
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  idx_intc #(.N_IRQ(N)) i_idx_intc (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o)
  );

  function automatic void check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endfunction

  // monitor: compare each completed read against the scoreboard
  always @(posedge clk) rd_seen <= req & ~we;
  always @(negedge clk) begin : mon
    exp_t e;
    if (rd_seen) begin
      if (q.size() == 0) check(rdata, 32'hx, "scoreboard empty");
      else begin
        e = q.pop_front();
        check(rdata, e.val, e.tag);
      end
    end
  end

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [12:0] a, logic [31:0] e, string tag);
    exp_t x;
    x.val = e; x.tag = tag;
    @(negedge clk); req = 1; we = 0; addr = a;
    q.push_back(x);
    @(negedge clk); req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(logic e, string tag);
    check({31'b0, irq_o}, {31'b0, e}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_irq(0, "R1 irq_o");
    rd(13'h080, 32'h8000_0000, "R1 prio none");
    rd(13'h400, 32'h0707_0707, "R1 chmap w0");
    rd(13'h43C, 32'h0707_0707, "R1 chmap last");
    rd(13'hD00, 32'hFFFF_FFFF, "R1 pol w0");
    rd(13'hD04, 32'hFFFF_FFFF, "R1 pol w1");
    rd(13'hD80, 32'h0, "R1 type w0");
    rd(13'h280, 32'h0, "R1 status");
    rd(13'h384, 32'h0, "R1 enable");
    rd(13'h010, 32'h0, "R1 global");

    // level-high, gating
    irq[5] = 1; idle(2);
    rd(13'h280, 32'h20, "R5 level-high status");
    rd(13'h080, 32'h8000_0000, "R8 disabled not reported");
    wr(13'h028, 5);
    rd(13'h380, 32'h20, "R2 enable index set");
    rd(13'h080, 32'd5, "R8 single winner");
    chk_irq(0, "R9 global off");
    wr(13'h010, 1);
    rd(13'h010, 32'h1, "R9 global readback");
    chk_irq(0, "R9 host off");
    wr(13'h034, 0);
    chk_irq(1, "R9 all gates on");
    wr(13'h038, 0);
    chk_irq(0, "R9 host cleared");
    wr(13'h034, 0);
    wr(13'h034, 3);
    chk_irq(1, "R9 host set non-zero ignored");
    wr(13'h028, 100);
    rd(13'h380, 32'h20, "R2 out-of-range index ignored");
    irq[5] = 0; idle(2);
    rd(13'h280, 32'h0, "R5 level follows input");
    chk_irq(0, "R9 nothing pending");

    // level-low on line 40
    wr(13'hD04, ~32'h100);
    idle(1);
    rd(13'h284, 32'h100, "R5 level-low active");
    rd(13'hD04, 32'hFFFF_FEFF, "R5 polarity readback");
    wr(13'h028, 40);
    rd(13'h080, 32'd40, "R8 winner 40");
    chk_irq(1, "R9 level-low drives irq");
    irq[40] = 1; idle(2);
    rd(13'h284, 32'h0, "R5 level-low inactive");
    chk_irq(0, "R9 level-low released");

    // rising edges on 10, 11
    wr(13'hD80, 32'hC00);
    @(negedge clk); irq[10] = 1; irq[11] = 1;
    @(negedge clk); irq[10] = 0; irq[11] = 0;
    idle(2);
    rd(13'h280, 32'hC00, "R6 edge sticky");
    wr(13'h024, 10);
    rd(13'h280, 32'h800, "R3 index clear one line");
    wr(13'h280, 32'h800);
    rd(13'h280, 32'h0, "R4 bank status clear");

    // falling edge on 33 (type first, then polarity)
    wr(13'hD84, 32'h2);
    wr(13'hD04, ~32'h102);
    irq[33] = 1; idle(2);
    rd(13'h284, 32'h0, "R5 falling ignores rise");
    irq[33] = 0; idle(2);
    rd(13'h284, 32'h2, "R5 falling latched");

    // priority
    @(negedge clk); irq[10] = 1; irq[11] = 1;
    @(negedge clk); irq[10] = 0; irq[11] = 0;
    wr(13'h028, 10); wr(13'h028, 11); wr(13'h028, 33);
    rd(13'h080, 32'd10, "R8 tie lowest number");
    wr(13'h420, 32'h0707_0207);
    rd(13'h080, 32'd33, "R8 lower channel wins");
    wr(13'h408, 32'h0107_0707);
    rd(13'h080, 32'd11, "R8 channel 1 beats 2");
    wr(13'h408, 32'h0101_0707);
    rd(13'h080, 32'd10, "R8 tie on channel 1");
    rd(13'h408, 32'h0101_0707, "R7 chmap readback");
    wr(13'h380, 32'h400);
    rd(13'h080, 32'd11, "R4 bank enable clear");
    rd(13'h380, 32'h820, "R4 enable word");
    wr(13'h02C, 11);
    rd(13'h080, 32'd33, "R2 enable index clear");
    wr(13'h024, 33);
    rd(13'h284, 32'h0, "R3 clear falling-edge line");
    rd(13'h080, 32'h8000_0000, "R8 none flag");
    rd(13'h384, 32'h102, "R2 enable word1");

    // set wins over same-cycle clear
    wr(13'h024, 10);
    rd(13'h280, 32'h800, "R3 clear 10");
    @(negedge clk); req = 1; we = 1; addr = 13'h024; wdata = 10; irq[10] = 1;
    @(negedge clk); req = 0; we = 0; irq[10] = 0;
    rd(13'h280, 32'hC00, "R6 edge beats clear");

    // unmapped / write-only
    rd(13'h004, 32'h0, "R10 mode reads zero");
    wr(13'h004, 32'hFFFF_FFFF);
    rd(13'h004, 32'h0, "R10 mode write ignored");
    rd(13'h00C, 32'h0, "R10 host mode zero");
    rd(13'h024, 32'h0, "R10 index reg zero");
    rd(13'h034, 32'h0, "R10 host index zero");
    wr(13'h1000, 32'hFFFF_FFFF);
    wr(13'h388, 32'hFFFF_FFFF);
    rd(13'h1000, 32'h0, "R10 unmapped read");
    rd(13'h388, 32'h0, "R10 beyond bank read");
    rd(13'h380, 32'h20, "R10 enables unchanged");
    rd(13'h280, 32'hC00, "R10 status unchanged");

    // timing of irq_o
    @(negedge clk); irq[5] = 1;
    #1 chk_irq(0, "R11 no change before edge");
    @(negedge clk);
    chk_irq(1, "R11 irq after one edge");
    rd(13'h080, 32'd5, "R11 winner 5");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule